// File: doc/BRIEF.md
# Bus Slave Status-Latch Front End

This block sits on the slave side of a parallel 8-bit microcomputer backplane with a 16-bit address bus. All bus signals are asynchronous to the local system clock. Each one passes through a two-flop synchronizer. The synchronized cycle-start (sync) signal is combined with the low half of the bus phase clock to form a status strobe. On that strobe the block captures the address and the six cycle-type status bits.

Different processor boards produce the status-valid timing in different ways. For that reason the strobe is always formed locally in the same way. It may fire twice inside one sync assertion, and repeated capture of identical values must be harmless. A memory or I/O chip select is decoded only from the captured values. That select then qualifies the bus read and write strobes to produce local read and write enables.

The local clock is assumed to run at least eight times faster than the bus phase clock. Every output is registered, so downstream logic sees no glitches.

Top module: `bus_slave_front`

## Requirements
- R1: While the synchronized sync input is high and the synchronized phase input is low, the address and status are captured. The captured address appears on `lat_addr`. Input changes reach the outputs within six local clock cycles.
- R2: Address and status changes are ignored while sync is high with phase high, and while sync is low. `lat_addr` and `chip_sel` keep the previously captured values.
- R3: A second strobe within one sync assertion, with unchanged inputs, leaves `lat_addr` and `chip_sel` constant on every clock cycle.
- R4: The status input uses this bit layout: bit0 memory-read, bit1 write-out, bit2 input, bit3 output, bit4 halt-acknowledge, bit5 hold-acknowledge. A memory select occurs when the captured status shows memory-read, or shows write-out low with neither I/O bit set. The captured address must also satisfy MEM_BASE <= address < MEM_BASE+MEM_SIZE.
- R5: An I/O select occurs when the captured input or output bit is set and the captured address bits 7:0 equal IO_PORT.
- R6: `chip_sel` depends only on the captured status and address. The bus read and write strobes do not change it.
- R7: A rising edge of synchronized sync clears `chip_sel` before the next status strobe of that cycle.
- R8: `rd_en` is high only while the bus read strobe is high, `chip_sel` is high, and the captured write-out bit is high.
- R9: `wr_en` is high only while the active-low bus write strobe is low, `chip_sel` is high, and the captured write-out bit is low.
- R10: Neither enable is asserted when the captured halt-acknowledge or hold-acknowledge bit is set.
- R11: A synchronous active-high reset clears the captured address, the captured status, `chip_sel`, `rd_en` and `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sync | input | 1 | Cycle-start signal from the bus |
| bus_phase | input | 1 | Bus phase clock |
| bus_rd | input | 1 | Bus read strobe, active high |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_stat | input | 6 | Cycle-type status bits (layout in R4) |
| bus_addr | input | 16 | Bus address |
| lat_addr | output | 16 | Captured address |
| chip_sel | output | 1 | Decoded select for memory or I/O |
| rd_en | output | 1 | Local read enable |
| wr_en | output | 1 | Local write enable |

## Verification
A wrong captured value or a stale select shows up at the ports in one of three ways. `lat_addr` differs from the address presented during the strobe. `chip_sel` is wrong after the status has settled. Or an enable is missing or spurious during the following strobe phase. All of these become visible within about six local clock cycles of the causing input.

The bench samples `chip_sel` and `lat_addr` on every clock cycle across a repeated strobe to expose a one-cycle glitch. It scrambles the bus pins outside the strobe window to expose a capture that happens when it should not.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;

    localparam int ADDR_W = 16;
    localparam int STAT_W = 6;

    // Bit 0 is memory-read, bit 5 is hold-acknowledge (packed MSB first).
    typedef struct packed {
        logic hold_ack;
        logic halt_ack;
        logic out_cyc;
        logic in_cyc;
        logic wr_out;
        logic mem_rd;
    } bus_stat_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MEM  = 2'd1,
        SEL_IO   = 2'd2
    } sel_kind_e;

    function automatic logic in_window(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W:0]   size
    );
        logic [ADDR_W:0] ext_a;
        logic [ADDR_W:0] ext_b;
        ext_a = {1'b0, a};
        ext_b = {1'b0, base};
        return (ext_a >= ext_b) && ((ext_a - ext_b) < size);
    endfunction

    function automatic logic is_mem_cycle(input bus_stat_t s);
        return s.mem_rd | (~s.wr_out & ~s.in_cyc & ~s.out_cyc);
    endfunction

    function automatic logic is_io_cycle(input bus_stat_t s);
        return s.in_cyc | s.out_cyc;
    endfunction

    function automatic logic is_ack_cycle(input bus_stat_t s);
        return s.halt_ack | s.hold_ack;
    endfunction

endpackage

// File: rtl/sfe_sync.sv
`timescale 1ns/1ps
module sfe_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/sfe_capture.sv
`timescale 1ns/1ps
module sfe_capture
    import sfe_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_sync,
    input  logic          s_phase,
    input  logic [AW-1:0] s_addr,
    input  bus_stat_t     s_stat,
    output logic          st_strobe,
    output logic          sync_rise,
    output logic [AW-1:0] lat_addr,
    output bus_stat_t     lat_stat,
    output logic          lat_valid
);

    logic sync_prev_q;

    // Status strobe: sync high while the phase clock is low.
    assign st_strobe = s_sync & ~s_phase;
    assign sync_rise = s_sync & ~sync_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_prev_q <= 1'b0;
            lat_addr    <= '0;
            lat_stat    <= '0;
            lat_valid   <= 1'b0;
        end else begin
            sync_prev_q <= s_sync;
            if (st_strobe) begin
                lat_addr  <= s_addr;
                lat_stat  <= s_stat;
                lat_valid <= 1'b1;
            end else if (sync_rise) begin
                lat_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sfe_decode.sv
`timescale 1ns/1ps
module sfe_decode
    import sfe_pkg::*;
#(
    parameter int            AW       = ADDR_W,
    parameter logic [AW-1:0] MEM_BASE = 16'h8000,
    parameter logic [AW:0]   MEM_SIZE = 17'h01000,
    parameter logic [7:0]    IO_PORT  = 8'h42
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] lat_addr,
    input  bus_stat_t     lat_stat,
    input  logic          lat_valid,
    input  logic          sync_rise,
    output logic          chip_sel
);

    sel_kind_e kind_d;
    sel_kind_e kind_q;

    always_comb begin
        kind_d = SEL_NONE;
        if (lat_valid) begin
            if (is_mem_cycle(lat_stat) && in_window(lat_addr, MEM_BASE, MEM_SIZE))
                kind_d = SEL_MEM;
            else if (is_io_cycle(lat_stat) && (lat_addr[7:0] == IO_PORT))
                kind_d = SEL_IO;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sync_rise)
            kind_q <= SEL_NONE;
        else
            kind_q <= kind_d;
    end

    assign chip_sel = (kind_q != SEL_NONE);

endmodule

// File: rtl/sfe_gate.sv
`timescale 1ns/1ps
module sfe_gate
    import sfe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      chip_sel,
    input  logic      sync_rise,
    input  logic      s_rd,
    input  logic      s_wr_n,
    input  bus_stat_t lat_stat,
    output logic      rd_en,
    output logic      wr_en
);

    logic allow;
    assign allow = chip_sel & ~sync_rise & ~is_ack_cycle(lat_stat);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en <= 1'b0;
            wr_en <= 1'b0;
        end else begin
            rd_en <= allow & s_rd & lat_stat.wr_out;
            wr_en <= allow & ~s_wr_n & ~lat_stat.wr_out;
        end
    end

endmodule

// File: rtl/bus_slave_front.sv
`timescale 1ns/1ps
module bus_slave_front
    import sfe_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MEM_BASE = 16'h8000,
    parameter logic [ADDR_W:0]   MEM_SIZE = 17'h01000,
    parameter logic [7:0]        IO_PORT  = 8'h42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sync,
    input  logic              bus_phase,
    input  logic              bus_rd,
    input  logic              bus_wr_n,
    input  logic [STAT_W-1:0] bus_stat,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              chip_sel,
    output logic              rd_en,
    output logic              wr_en
);

    localparam int SYNC_W = 4 + STAT_W + ADDR_W;
    // wr_n idles high, the phase clock idles high; everything else idles low.
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, 1'b1, {STAT_W{1'b0}}, {ADDR_W{1'b0}}};

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] syn_bus;

    logic              s_sync;
    logic              s_phase;
    logic              s_rd;
    logic              s_wr_n;
    bus_stat_t         s_stat;
    logic [ADDR_W-1:0] s_addr;

    logic              st_strobe;
    logic              sync_rise;
    bus_stat_t         lat_stat;
    logic              lat_valid;

    assign raw_bus = {bus_sync, bus_phase, bus_rd, bus_wr_n, bus_stat, bus_addr};

    sfe_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (syn_bus)
    );

    assign {s_sync, s_phase, s_rd, s_wr_n, s_stat, s_addr} = syn_bus;

    sfe_capture #(.AW(ADDR_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .s_sync    (s_sync),
        .s_phase   (s_phase),
        .s_addr    (s_addr),
        .s_stat    (s_stat),
        .st_strobe (st_strobe),
        .sync_rise (sync_rise),
        .lat_addr  (lat_addr),
        .lat_stat  (lat_stat),
        .lat_valid (lat_valid)
    );

    sfe_decode #(
        .AW       (ADDR_W),
        .MEM_BASE (MEM_BASE),
        .MEM_SIZE (MEM_SIZE),
        .IO_PORT  (IO_PORT)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .lat_addr  (lat_addr),
        .lat_stat  (lat_stat),
        .lat_valid (lat_valid),
        .sync_rise (sync_rise),
        .chip_sel  (chip_sel)
    );

    sfe_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .chip_sel  (chip_sel),
        .sync_rise (sync_rise),
        .s_rd      (s_rd),
        .s_wr_n    (s_wr_n),
        .lat_stat  (lat_stat),
        .rd_en     (rd_en),
        .wr_en     (wr_en)
    );

endmodule

// File: rtl/bus_slave_front_chk.sv
`timescale 1ns/1ps
module bus_slave_front_chk
    import sfe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              st_strobe,
    input logic              sync_rise,
    input logic [ADDR_W-1:0] lat_addr,
    input bus_stat_t         lat_stat,
    input logic              chip_sel,
    input logic              rd_en,
    input logic              wr_en
);

    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (rst)
        !st_strobe |=> $stable(lat_addr)); // R2

    AST_CS_CLEAR_RISE: assert property (@(posedge clk) disable iff (rst)
        sync_rise |=> !chip_sel); // R7

    AST_RD_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> $past(chip_sel)); // R8

    AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(chip_sel)); // R9

    AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en)); // R8

    AST_ACK_NO_EN: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |-> !($past(lat_stat.halt_ack) || $past(lat_stat.hold_ack))); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (lat_addr == '0 && lat_stat == '0 && !chip_sel && !rd_en && !wr_en)); // R11

endmodule

bind bus_slave_front bus_slave_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_strobe (st_strobe),
    .sync_rise (sync_rise),
    .lat_addr  (lat_addr),
    .lat_stat  (lat_stat),
    .chip_sel  (chip_sel),
    .rd_en     (rd_en),
    .wr_en     (wr_en)
);

// File: tb/sim_bus_slave_front.sv
`timescale 1ns/1ps
module sim_bus_slave_front;

    localparam logic [15:0] BASE   = 16'h8000;
    localparam logic [16:0] SIZE   = 17'h01000;
    localparam logic [7:0]  PORT   = 8'h42;
    localparam int          SETTLE = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sync = 1'b0;
    logic        bus_phase = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr_n = 1'b1;
    logic [5:0]  bus_stat = '0;
    logic [15:0] bus_addr = '0;
    logic [15:0] lat_addr;
    logic        chip_sel;
    logic        rd_en;
    logic        wr_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_slave_front u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sync  (bus_sync),
        .bus_phase (bus_phase),
        .bus_rd    (bus_rd),
        .bus_wr_n  (bus_wr_n),
        .bus_stat  (bus_stat),
        .bus_addr  (bus_addr),
        .lat_addr  (lat_addr),
        .chip_sel  (chip_sel),
        .rd_en     (rd_en),
        .wr_en     (wr_en)
    );

    // Status bits: 0 memory-read, 1 write-out, 2 input, 3 output, 4 halt ack, 5 hold ack.
    function automatic logic exp_sel(input logic [5:0] st, input logic [15:0] a);
        logic mem;
        logic io;
        logic win;
        win = ({1'b0, a} >= {1'b0, BASE}) && (({1'b0, a} - {1'b0, BASE}) < SIZE);
        mem = (st[0] | (~st[1] & ~st[2] & ~st[3])) & win;
        io  = (st[2] | st[3]) & (a[7:0] == PORT);
        return mem | io;
    endfunction

    function automatic logic exp_rd(input logic [5:0] st, input logic [15:0] a, input logic rd);
        return exp_sel(st, a) & rd & st[1] & ~st[4] & ~st[5];
    endfunction

    function automatic logic exp_wr(input logic [5:0] st, input logic [15:0] a, input logic wr_n);
        return exp_sel(st, a) & ~wr_n & ~st[1] & ~st[4] & ~st[5];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_cycle(input logic [5:0] st, input logic [15:0] a,
                             input bit twice, input bit do_rd, input bit do_wr);
        logic [15:0] prev_addr;
        logic        sel;
        bit          bad;
        prev_addr = lat_addr;
        sel = exp_sel(st, a);
        // Sync rises with phase high: no capture yet, select cleared.
        bus_stat = st; bus_addr = a; bus_sync = 1'b1; bus_phase = 1'b1;
        settle();
        check("R7 chip_sel cleared on sync rise", 32'(chip_sel), 32'd0);
        check("R2 no capture with phase high", 32'(lat_addr), 32'(prev_addr));
        // Phase low: strobe active.
        bus_phase = 1'b0;
        settle();
        check("R1 captured address", 32'(lat_addr), 32'(a));
        check(st[2] | st[3] ? "R5 io select" : "R4 memory select", 32'(chip_sel), 32'(sel));
        if (twice) begin
            bad = 1'b0;
            bus_phase = 1'b1;
            for (int i = 0; i < 2 * SETTLE; i++) begin
                @(negedge clk);
                if (i == SETTLE) bus_phase = 1'b0;
                if (chip_sel !== sel || lat_addr !== a) bad = 1'b1;
            end
            check("R3 repeated strobe steady", 32'(bad), 32'd0);
        end
        // Sync drops, pins scrambled, data strobes applied.
        bus_sync = 1'b0;
        bus_phase = 1'($urandom_range(0, 1));
        bus_addr = 16'($urandom());
        bus_stat = 6'($urandom());
        bus_rd = do_rd;
        bus_wr_n = ~do_wr;
        settle();
        check("R2 pins ignored outside strobe", 32'(lat_addr), 32'(a));
        check("R6 select unaffected by strobes", 32'(chip_sel), 32'(sel));
        check((st[4] | st[5]) ? "R10 rd_en in ack cycle" : "R8 rd_en", 32'(rd_en), 32'(exp_rd(st, a, do_rd)));
        check((st[4] | st[5]) ? "R10 wr_en in ack cycle" : "R9 wr_en", 32'(wr_en), 32'(exp_wr(st, a, ~do_wr)));
        bus_rd = 1'b0; bus_wr_n = 1'b1; bus_phase = 1'b1;
        settle();
        check("R8 rd_en drops with strobe", 32'(rd_en), 32'd0);
        check("R9 wr_en drops with strobe", 32'(wr_en), 32'd0);
    endtask

    function automatic logic [15:0] pick_addr(input bit io);
        int k;
        k = $urandom_range(0, 5);
        if (io) begin
            case (k)
                0, 1: return {8'($urandom()), PORT};
                2:    return {8'($urandom()), PORT + 8'd1};
                3:    return {8'($urandom()), PORT - 8'd1};
                default: return 16'($urandom());
            endcase
        end
        case (k)
            0: return BASE;
            1: return 16'({1'b0, BASE} + SIZE - 17'd1);
            2: return 16'({1'b0, BASE} + SIZE);
            3: return BASE - 16'd1;
            4: return BASE + 16'($urandom_range(0, 32'(SIZE) - 1));
            default: return 16'($urandom());
        endcase
    endfunction

    function automatic logic [5:0] pick_stat(input int kind);
        case (kind)
            0: return 6'b000011;  // memory read
            1: return 6'b000000;  // memory write
            2: return 6'b000110;  // input
            3: return 6'b001000;  // output
            4: return 6'b010011;  // halt acknowledge
            default: return 6'b100011;  // hold acknowledge
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stimulus
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R11 reset lat_addr", 32'(lat_addr), 32'd0);
        check("R11 reset chip_sel", 32'(chip_sel), 32'd0);
        check("R11 reset enables", {30'd0, rd_en, wr_en}, 32'd0);
        rst = 1'b0;
        settle();
        // Directed corners.
        bus_cycle(6'b000011, BASE, 1'b1, 1'b1, 1'b0);
        bus_cycle(6'b000000, 16'({1'b0, BASE} + SIZE - 17'd1), 1'b0, 1'b0, 1'b1);
        bus_cycle(6'b000011, 16'({1'b0, BASE} + SIZE), 1'b0, 1'b1, 1'b0);
        bus_cycle(6'b000110, {8'hA5, PORT}, 1'b1, 1'b1, 1'b0);
        bus_cycle(6'b001000, {8'h00, PORT}, 1'b0, 1'b0, 1'b1);
        bus_cycle(6'b010011, BASE, 1'b0, 1'b1, 1'b0);
        bus_cycle(6'b100000, BASE, 1'b0, 1'b0, 1'b1);
        bus_cycle(6'b000011, BASE, 1'b0, 1'b0, 1'b1);
        // Reset in mid-operation.
        bus_cycle(6'b000011, BASE + 16'd4, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R11 mid-run reset lat_addr", 32'(lat_addr), 32'd0);
        check("R11 mid-run reset chip_sel", 32'(chip_sel), 32'd0);
        rst = 1'b0;
        settle();
        // Random cycles.
        for (int n = 0; n < 160; n++) begin
            int kind;
            kind = $urandom_range(0, 5);
            bus_cycle(pick_stat(kind), pick_addr(kind == 2 || kind == 3),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule